// File: doc/BRIEF.md
# Dual-Bank CPU Register File

This block holds the general-purpose working registers of a small 16-bit CPU core. There are two banks. Each bank has seven 16-bit registers: four data registers (R0 to R3), two address registers (A0, A1) and a frame base register (FB). A one-bit bank select, driven by a flag in the processor status word, picks the bank that every port uses in the current cycle. The block has one write port and two independent read ports.

Every port takes a 3-bit register index and a 2-bit access code. Access codes allow plain 16-bit word access to any register, and byte access to the low or high half of R0 and R1. They also allow 32-bit access to three register pairs, whose upper members are fixed by the lower index: R2 over R0, R3 over R1 and A1 over A0. Index and access-code combinations that the register does not support have no effect on a write and read back as zero. Storage is a plain flip-flop array. A write lands on the clock edge, and the read ports are combinational from that array.

Top module: `dual_bank_regfile`

## Requirements
- R1: When rst_ni is low, every register in both banks is cleared to zero, whatever the clock is doing.
- R2: When bank_i is 0, all ports use bank 0, and when it is 1 they use bank 1. A write to one bank leaves every register of the other bank unchanged.
- R3: Register indices are 0=R0, 1=R1, 2=R2, 3=R3, 4=A0, 5=A1, 6=FB. Access code 0 is a 16-bit word access. A word read returns the register in bits 15:0, with bits 31:16 zero. A word write stores wdata_i[15:0].
- R4: Access code 1 is a low-byte access to R0 or R1. A write stores wdata_i[7:0] in bits 7:0 and leaves bits 15:8 unchanged. A read returns bits 7:0 in rdata[7:0], with all other bits zero.
- R5: Access code 2 is a high-byte access to R0 or R1. A write stores wdata_i[7:0] in bits 15:8 and leaves bits 7:0 unchanged. A read returns bits 15:8 in rdata[7:0], with all other bits zero.
- R6: Access code 3 is a 32-bit pair access at index 0 ({R2,R0}), index 1 ({R3,R1}) or index 4 ({A1,A0}). The upper register maps to bits 31:16. A pair write updates both 16-bit members on the same clock edge.
- R7: The following combinations are unsupported: byte access at any index other than 0 or 1, pair access at any index other than 0, 1 or 4, and any access at index 7. A write with an unsupported combination changes no register, and a read with one returns zero.
- R8: A read in the cycle after a write returns the written value. A read in the same cycle as the write returns the value held before that write.
- R9: The two read ports decode their own index and access code independently and can read different registers in the same cycle.
- R10: When we_i is low, no register changes, whatever the write address, access code and data are.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| bank_i | input | 1 | Bank select for all ports |
| we_i | input | 1 | Write enable |
| waddr_i | input | 3 | Write register index |
| wacc_i | input | 2 | Write access code |
| wdata_i | input | 32 | Write data (word and byte use the low bits) |
| raddr_a_i | input | 3 | Read port A register index |
| racc_a_i | input | 2 | Read port A access code |
| rdata_a_o | output | 32 | Read port A data |
| raddr_b_i | input | 3 | Read port B register index |
| racc_b_i | input | 2 | Read port B access code |
| rdata_b_o | output | 32 | Read port B data |

## Verification
The bench targets byte writes into R0 and R1. A design that writes the full word would wipe out the other half, and one that swaps the halves would show the byte in the wrong place. It writes each register pair and then reads the two members on their own. This catches a pair mapped to the wrong upper register, or one that updates only one member. It drives unsupported index and access combinations on both ports. A design that lets these through would corrupt a real register or return non-zero data. It also covers same-cycle read against next-cycle read, writes with we_i low, and keeping the two banks apart, including a reset asserted in the middle of a run.

// File: rtl/rf_pkg.sv
package rf_pkg;
  localparam int unsigned REG_IDX_W = 3;

  typedef enum logic [1:0] {
    ACC_W16 = 2'd0,
    ACC_LO8 = 2'd1,
    ACC_HI8 = 2'd2,
    ACC_W32 = 2'd3
  } acc_e;

  localparam logic [REG_IDX_W-1:0] IDX_R0 = 3'd0;
  localparam logic [REG_IDX_W-1:0] IDX_R1 = 3'd1;
  localparam logic [REG_IDX_W-1:0] IDX_R2 = 3'd2;
  localparam logic [REG_IDX_W-1:0] IDX_R3 = 3'd3;
  localparam logic [REG_IDX_W-1:0] IDX_A0 = 3'd4;
  localparam logic [REG_IDX_W-1:0] IDX_A1 = 3'd5;

  function automatic logic byte_ok(input logic [REG_IDX_W-1:0] idx);
    return (idx == IDX_R0) || (idx == IDX_R1);
  endfunction

  function automatic logic pair_ok(input logic [REG_IDX_W-1:0] idx);
    return (idx == IDX_R0) || (idx == IDX_R1) || (idx == IDX_A0);
  endfunction

  // upper member of a 32-bit pair named by its lower index
  function automatic logic [REG_IDX_W-1:0] pair_hi(input logic [REG_IDX_W-1:0] idx);
    case (idx)
      IDX_R0:  return IDX_R2;
      IDX_R1:  return IDX_R3;
      default: return IDX_A1;
    endcase
  endfunction
endpackage

// File: rtl/rf_wr_decode.sv
module rf_wr_decode
  import rf_pkg::*;
#(
  parameter int unsigned DATA_W   = 16,
  parameter int unsigned NUM_REGS = 7
) (
  input  logic                                we_i,
  input  logic [REG_IDX_W-1:0]                idx_i,
  input  logic [1:0]                          acc_i,
  input  logic [2*DATA_W-1:0]                 data_i,
  output logic [NUM_REGS-1:0]                 we_lo_o,
  output logic [NUM_REGS-1:0]                 we_hi_o,
  output logic [NUM_REGS-1:0][DATA_W-1:0]     wd_o
);
  localparam int unsigned HALF_W = DATA_W / 2;

  logic idx_valid;
  assign idx_valid = 32'(idx_i) < NUM_REGS;

  for (genvar r = 0; r < NUM_REGS; r++) begin : g_reg
    localparam logic [REG_IDX_W-1:0] MY = REG_IDX_W'(r);
    always_comb begin
      we_lo_o[r] = 1'b0;
      we_hi_o[r] = 1'b0;
      wd_o[r]    = data_i[DATA_W-1:0];
      if (we_i && idx_valid) begin
        unique case (acc_e'(acc_i))
          ACC_W16: if (idx_i == MY) begin
            we_lo_o[r] = 1'b1;
            we_hi_o[r] = 1'b1;
          end
          ACC_LO8: if (idx_i == MY && byte_ok(idx_i)) begin
            we_lo_o[r] = 1'b1;
            wd_o[r]    = {{HALF_W{1'b0}}, data_i[HALF_W-1:0]};
          end
          ACC_HI8: if (idx_i == MY && byte_ok(idx_i)) begin
            we_hi_o[r] = 1'b1;
            wd_o[r]    = {data_i[HALF_W-1:0], {HALF_W{1'b0}}};
          end
          ACC_W32: if (pair_ok(idx_i)) begin
            if (idx_i == MY) begin
              we_lo_o[r] = 1'b1;
              we_hi_o[r] = 1'b1;
            end else if (pair_hi(idx_i) == MY) begin
              we_lo_o[r] = 1'b1;
              we_hi_o[r] = 1'b1;
              wd_o[r]    = data_i[2*DATA_W-1:DATA_W];
            end
          end
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/rf_bank_store.sv
module rf_bank_store
  import rf_pkg::*;
#(
  parameter int unsigned DATA_W    = 16,
  parameter int unsigned NUM_REGS  = 7,
  parameter int unsigned NUM_BANKS = 2,
  localparam int unsigned BANK_W   = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1
) (
  input  logic                                          clk_i,
  input  logic                                          rst_ni,
  input  logic [BANK_W-1:0]                             bank_i,
  input  logic [NUM_REGS-1:0]                           we_lo_i,
  input  logic [NUM_REGS-1:0]                           we_hi_i,
  input  logic [NUM_REGS-1:0][DATA_W-1:0]               wd_i,
  output logic [NUM_BANKS-1:0][NUM_REGS-1:0][DATA_W-1:0] regs_o
);
  localparam int unsigned HALF_W = DATA_W / 2;

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    logic sel;
    assign sel = (bank_i == BANK_W'(b));
    for (genvar r = 0; r < NUM_REGS; r++) begin : g_reg
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
          regs_o[b][r] <= '0;
        end else if (sel) begin
          if (we_lo_i[r]) regs_o[b][r][HALF_W-1:0]      <= wd_i[r][HALF_W-1:0];
          if (we_hi_i[r]) regs_o[b][r][DATA_W-1:HALF_W] <= wd_i[r][DATA_W-1:HALF_W];
        end
      end
    end
  end
endmodule

// File: rtl/rf_rd_port.sv
module rf_rd_port
  import rf_pkg::*;
#(
  parameter int unsigned DATA_W   = 16,
  parameter int unsigned NUM_REGS = 7
) (
  input  logic [NUM_REGS-1:0][DATA_W-1:0] regs_i,
  input  logic [REG_IDX_W-1:0]            idx_i,
  input  logic [1:0]                      acc_i,
  output logic [2*DATA_W-1:0]             data_o
);
  localparam int unsigned HALF_W = DATA_W / 2;

  logic [DATA_W-1:0] sel_lo;
  logic [DATA_W-1:0] sel_hi;

  always_comb begin
    sel_lo = '0;
    sel_hi = '0;
    for (int r = 0; r < NUM_REGS; r++) begin
      if (idx_i == REG_IDX_W'(r))          sel_lo = regs_i[r];
      if (pair_hi(idx_i) == REG_IDX_W'(r)) sel_hi = regs_i[r];
    end
  end

  always_comb begin
    data_o = '0;
    unique case (acc_e'(acc_i))
      ACC_W16: data_o = {{DATA_W{1'b0}}, sel_lo};
      ACC_LO8: if (byte_ok(idx_i)) data_o = {{(2*DATA_W-HALF_W){1'b0}}, sel_lo[HALF_W-1:0]};
      ACC_HI8: if (byte_ok(idx_i)) data_o = {{(2*DATA_W-HALF_W){1'b0}}, sel_lo[DATA_W-1:HALF_W]};
      ACC_W32: if (pair_ok(idx_i)) data_o = {sel_hi, sel_lo};
      default: data_o = '0;
    endcase
  end
endmodule

// File: rtl/dual_bank_regfile.sv
module dual_bank_regfile
  import rf_pkg::*;
#(
  parameter int unsigned DATA_W    = 16,
  parameter int unsigned NUM_REGS  = 7,
  parameter int unsigned NUM_BANKS = 2,
  localparam int unsigned BANK_W   = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic [BANK_W-1:0]      bank_i,
  input  logic                   we_i,
  input  logic [REG_IDX_W-1:0]   waddr_i,
  input  logic [1:0]             wacc_i,
  input  logic [2*DATA_W-1:0]    wdata_i,
  input  logic [REG_IDX_W-1:0]   raddr_a_i,
  input  logic [1:0]             racc_a_i,
  output logic [2*DATA_W-1:0]    rdata_a_o,
  input  logic [REG_IDX_W-1:0]   raddr_b_i,
  input  logic [1:0]             racc_b_i,
  output logic [2*DATA_W-1:0]    rdata_b_o
);
  logic [NUM_REGS-1:0]                            we_lo;
  logic [NUM_REGS-1:0]                            we_hi;
  logic [NUM_REGS-1:0][DATA_W-1:0]                wd;
  logic [NUM_BANKS-1:0][NUM_REGS-1:0][DATA_W-1:0] regs;
  logic [NUM_REGS-1:0][DATA_W-1:0]                cur_regs;

  rf_wr_decode #(.DATA_W(DATA_W), .NUM_REGS(NUM_REGS)) u_wr_decode (
    .we_i    (we_i),
    .idx_i   (waddr_i),
    .acc_i   (wacc_i),
    .data_i  (wdata_i),
    .we_lo_o (we_lo),
    .we_hi_o (we_hi),
    .wd_o    (wd)
  );

  rf_bank_store #(.DATA_W(DATA_W), .NUM_REGS(NUM_REGS), .NUM_BANKS(NUM_BANKS)) u_store (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .bank_i  (bank_i),
    .we_lo_i (we_lo),
    .we_hi_i (we_hi),
    .wd_i    (wd),
    .regs_o  (regs)
  );

  always_comb begin
    cur_regs = regs[0];
    for (int b = 0; b < NUM_BANKS; b++)
      if (bank_i == BANK_W'(b)) cur_regs = regs[b];
  end

  rf_rd_port #(.DATA_W(DATA_W), .NUM_REGS(NUM_REGS)) u_rd_a (
    .regs_i (cur_regs),
    .idx_i  (raddr_a_i),
    .acc_i  (racc_a_i),
    .data_o (rdata_a_o)
  );

  rf_rd_port #(.DATA_W(DATA_W), .NUM_REGS(NUM_REGS)) u_rd_b (
    .regs_i (cur_regs),
    .idx_i  (raddr_b_i),
    .acc_i  (racc_b_i),
    .data_o (rdata_b_o)
  );
endmodule

// File: rtl/dual_bank_regfile_chk.sv
module dual_bank_regfile_chk
  import rf_pkg::*;
#(
  parameter int unsigned DATA_W = 16,
  parameter int unsigned BANK_W = 1
) (
  input logic                 clk_i,
  input logic                 rst_ni,
  input logic [BANK_W-1:0]    bank_i,
  input logic                 we_i,
  input logic [REG_IDX_W-1:0] waddr_i,
  input logic [1:0]           wacc_i,
  input logic [2*DATA_W-1:0]  wdata_i,
  input logic [REG_IDX_W-1:0] raddr_a_i,
  input logic [1:0]           racc_a_i,
  input logic [2*DATA_W-1:0]  rdata_a_o,
  input logic [REG_IDX_W-1:0] raddr_b_i,
  input logic [1:0]           racc_b_i,
  input logic [2*DATA_W-1:0]  rdata_b_o
);
  localparam int unsigned HALF_W = DATA_W / 2;

  logic a_bad, b_bad;
  assign a_bad = (raddr_a_i == 3'd7) ||
                 (racc_a_i inside {ACC_LO8, ACC_HI8} && !byte_ok(raddr_a_i)) ||
                 (racc_a_i == ACC_W32 && !pair_ok(raddr_a_i));
  assign b_bad = (raddr_b_i == 3'd7) ||
                 (racc_b_i inside {ACC_LO8, ACC_HI8} && !byte_ok(raddr_b_i)) ||
                 (racc_b_i == ACC_W32 && !pair_ok(raddr_b_i));

  assert_bad_read_a_zero_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    a_bad |-> rdata_a_o == '0);

  assert_bad_read_b_zero_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    b_bad |-> rdata_b_o == '0);

  assert_byte_read_width_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (racc_a_i inside {ACC_LO8, ACC_HI8}) |-> rdata_a_o[2*DATA_W-1:HALF_W] == '0);

  assert_word_read_width_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (racc_b_i == ACC_W16) |-> rdata_b_o[2*DATA_W-1:DATA_W] == '0);

  assert_no_write_no_change_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!$past(we_i) && $stable(raddr_a_i) && $stable(racc_a_i) && $stable(bank_i))
      |-> $stable(rdata_a_o));

  assert_write_visible_next_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(we_i && wacc_i == ACC_W16 && waddr_i != 3'd7) &&
     raddr_a_i == $past(waddr_i) && racc_a_i == ACC_W16 && bank_i == $past(bank_i))
      |-> rdata_a_o[DATA_W-1:0] == $past(wdata_i[DATA_W-1:0]));
endmodule

bind dual_bank_regfile dual_bank_regfile_chk #(.DATA_W(DATA_W), .BANK_W(BANK_W)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .bank_i    (bank_i),
  .we_i      (we_i),
  .waddr_i   (waddr_i),
  .wacc_i    (wacc_i),
  .wdata_i   (wdata_i),
  .raddr_a_i (raddr_a_i),
  .racc_a_i  (racc_a_i),
  .rdata_a_o (rdata_a_o),
  .raddr_b_i (raddr_b_i),
  .racc_b_i  (racc_b_i),
  .rdata_b_o (rdata_b_o)
);

// File: tb/dual_bank_regfile_bench.sv
module dual_bank_regfile_bench;
  logic        clk_i = 1'b0;
  logic        rst_ni;
  logic        bank_i;
  logic        we_i;
  logic [2:0]  waddr_i;
  logic [1:0]  wacc_i;
  logic [31:0] wdata_i;
  logic [2:0]  raddr_a_i;
  logic [1:0]  racc_a_i;
  logic [31:0] rdata_a_o;
  logic [2:0]  raddr_b_i;
  logic [1:0]  racc_b_i;
  logic [31:0] rdata_b_o;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  always #2.5 clk_i = ~clk_i;

  dual_bank_regfile u_dual_bank_regfile (.*);

  // {bank, waddr, wacc, wdata, raddr, racc, expected}; acc 0=W16 1=LO8 2=HI8 3=W32
  localparam int NV = 17;
  localparam logic [74:0] VEC [NV] = '{
    {1'b0, 3'd0, 2'd0, 32'h0000_1234, 3'd0, 2'd0, 32'h0000_1234}, // R3
    {1'b0, 3'd0, 2'd2, 32'h0000_00AB, 3'd0, 2'd0, 32'h0000_AB34}, // R5
    {1'b0, 3'd0, 2'd1, 32'h0000_00CD, 3'd0, 2'd2, 32'h0000_00AB}, // R4
    {1'b0, 3'd2, 2'd0, 32'h0000_5678, 3'd0, 2'd3, 32'h5678_ABCD}, // R6
    {1'b0, 3'd1, 2'd3, 32'hDEAD_BEEF, 3'd3, 2'd0, 32'h0000_DEAD}, // R6
    {1'b0, 3'd4, 2'd3, 32'h00C0_FFEE, 3'd5, 2'd0, 32'h0000_00C0}, // R6
    {1'b1, 3'd6, 2'd0, 32'h0000_7777, 3'd6, 2'd0, 32'h0000_7777}, // R2
    {1'b1, 3'd0, 2'd0, 32'h0000_1111, 3'd0, 2'd3, 32'h0000_1111}, // R2
    {1'b0, 3'd2, 2'd1, 32'h0000_00FF, 3'd2, 2'd0, 32'h0000_5678}, // R7
    {1'b0, 3'd4, 2'd2, 32'h0000_0099, 3'd4, 2'd0, 32'h0000_FFEE}, // R7
    {1'b0, 3'd6, 2'd3, 32'h1234_5678, 3'd6, 2'd0, 32'h0000_0000}, // R7
    {1'b0, 3'd7, 2'd0, 32'h0000_AAAA, 3'd7, 2'd0, 32'h0000_0000}, // R7
    {1'b0, 3'd1, 2'd1, 32'h0000_0042, 3'd1, 2'd0, 32'h0000_BE42}, // R4
    {1'b1, 3'd1, 2'd2, 32'h0000_005A, 3'd1, 2'd0, 32'h0000_5A00}, // R5
    {1'b0, 3'd3, 2'd0, 32'h0000_0001, 3'd1, 2'd3, 32'h0001_BE42}, // R6
    {1'b0, 3'd5, 2'd0, 32'h0000_2222, 3'd4, 2'd3, 32'h2222_FFEE}, // R6
    {1'b0, 3'd2, 2'd3, 32'h0000_0001, 3'd2, 2'd3, 32'h0000_0000}  // R7
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %08h expected %08h", req, act, exp);
    end
  endtask

  task automatic do_write(input logic b, input logic [2:0] a, input logic [1:0] c, input logic [31:0] d);
    @(negedge clk_i);
    bank_i = b; we_i = 1'b1; waddr_i = a; wacc_i = c; wdata_i = d;
    @(posedge clk_i);
    @(negedge clk_i);
    we_i = 1'b0;
  endtask

  task automatic read_a(input logic b, input logic [2:0] a, input logic [1:0] c);
    bank_i = b; raddr_a_i = a; racc_a_i = c;
    #1;
  endtask

  initial begin
    rst_ni = 1'b0; bank_i = 1'b0; we_i = 1'b0; waddr_i = '0; wacc_i = '0; wdata_i = '0;
    raddr_a_i = '0; racc_a_i = '0; raddr_b_i = '0; racc_b_i = '0;
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;

    // R1 reset state, both banks
    for (int b = 0; b < 2; b++)
      for (int r = 0; r < 7; r++) begin
        read_a(b[0], r[2:0], 2'd0);
        check("R1 reset", rdata_a_o, 32'h0);
      end

    for (int i = 0; i < NV; i++) begin
      logic [74:0] v;
      v = VEC[i];
      do_write(v[74], v[73:71], v[70:69], v[68:37]);
      read_a(v[74], v[36:34], v[33:32]);
      check($sformatf("R3 R4 R5 R6 R7 vector %0d", i), rdata_a_o, v[31:0]);
    end

    // R8: same-cycle read sees old value, next cycle sees new
    @(negedge clk_i);
    bank_i = 1'b0; we_i = 1'b1; waddr_i = 3'd0; wacc_i = 2'd0; wdata_i = 32'h4321;
    raddr_a_i = 3'd0; racc_a_i = 2'd0;
    #1 check("R8 same cycle", rdata_a_o, 32'h0000_ABCD);
    @(negedge clk_i);
    we_i = 1'b0;
    #1 check("R8 next cycle", rdata_a_o, 32'h0000_4321);

    // R9: two ports, different registers and codes
    @(negedge clk_i);
    bank_i = 1'b0; raddr_a_i = 3'd4; racc_a_i = 2'd3; raddr_b_i = 3'd2; racc_b_i = 2'd0;
    #1;
    check("R9 port a", rdata_a_o, 32'h2222_FFEE);
    check("R9 port b", rdata_b_o, 32'h0000_5678);
    raddr_b_i = 3'd3; racc_b_i = 2'd1;
    #1 check("R7 port b bad byte", rdata_b_o, 32'h0);

    // R10: write data presented with we_i low
    @(negedge clk_i);
    we_i = 1'b0; waddr_i = 3'd0; wacc_i = 2'd0; wdata_i = 32'hFFFF_FFFF;
    repeat (2) @(negedge clk_i);
    read_a(1'b0, 3'd0, 2'd0);
    check("R10 no write", rdata_a_o, 32'h0000_4321);

    // R2: banks hold separate values
    read_a(1'b1, 3'd0, 2'd0);
    check("R2 bank1 R0", rdata_a_o, 32'h0000_1111);
    read_a(1'b0, 3'd6, 2'd0);
    check("R2 bank0 FB", rdata_a_o, 32'h0);

    // R1: asynchronous reset mid-run
    @(negedge clk_i);
    rst_ni = 1'b0;
    #1;
    read_a(1'b1, 3'd6, 2'd0);
    check("R1 mid reset bank1 FB", rdata_a_o, 32'h0);
    read_a(1'b0, 3'd0, 2'd3);
    check("R1 mid reset bank0 pair", rdata_a_o, 32'h0);
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk_i);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule